// File: doc/BRIEF.md
# Three-Region Bank-Switching Address Translator

This block maps a 16-bit logical address onto a 20-bit physical address, so a CPU that sees only 64KB can reach 1MB of memory. The logical space is divided on 4KB page boundaries into three regions:

- **Low region.** Starts at logical 0 and is passed through unchanged.
- **Window region.** A movable window whose physical placement is set by a base register.
- **High region.** A movable region at the top, with its own base register.

A single split register holds two 4-bit page numbers that set where the window and the high region begin. Software changes the split register and the two base registers through a small port interface (select, write strobe, write data and registered read data). Rewriting the window base at run time slides the window over different physical memory.

Each translation is registered, so the result appears one cycle after the logical address. It comes with a valid flag and a region code. The movable regions add their base (in 4KB units) to the whole logical address, and do not replace its upper bits. The sum wraps modulo 1MB.

Top module: `bank_xlate`

## Requirements
- R1: After synchronous reset, the split register reads 0xF0 and both base registers read 0x00, so every logical address translates to the same physical address. phys_valid is 0 during reset.
- R2: When the logical page (bits 15:12) is below the window start (split bits 3:0), the physical address is the logical address zero-extended and the region code is 0.
- R3: When the page is at or above the window start and below the high start (split bits 7:4), the physical address is (window_base << 12) + logical and the region code is 1.
- R4: When the page is at or above the high start, the physical address is (high_base << 12) + logical and the region code is 2.
- R5: When the window start exceeds the high start, the window is empty. A page at or above the window start then goes to the high region, and region code 1 never appears.
- R6: The base-plus-address sum is taken modulo 2^20.
- R7: phys_addr, phys_region and phys_valid reflect the log_addr and log_valid of the previous cycle.
- R8: A register write is applied to translations of addresses presented in the following cycles. An address presented in the same cycle as the write uses the old value.
- R9: cfg_sel selects the split register (0), the window base (1) or the high base (2). cfg_rdata returns the selected register one cycle after the select. Selector 3 reads 0, and writes to selector 3 change nothing.
- R10: With split 0x84 and window base 0x08, logical 0x4000 translates to physical 0x0C000 in region 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sel | input | 2 | Register select: 0 split, 1 window base, 2 high base, 3 none |
| cfg_wr | input | 1 | Write strobe for the selected register |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Registered read data of the register selected in the previous cycle |
| log_valid | input | 1 | Logical address is valid |
| log_addr | input | 16 | Logical address |
| phys_valid | output | 1 | Registered valid for the translation |
| phys_addr | output | 20 | Registered physical address |
| phys_region | output | 2 | Registered region code: 0 low, 1 window, 2 high |

## Verification
The bench runs through all 256 split values and probes every logical page under each one, so it exercises:

- **Boundary compares.** An off-by-one compare would move a page into the wrong region at exactly the boundary page.
- **Empty window.** A decode that tests the window before the high region would emit region 1 when the window start exceeds the high start.
- **Carry out of bit 19.** A wrong-width adder would drop it or spill it.

Two further checks target timing and selector handling. A translation is placed in the very cycle of a base write, where forwarding the new value would give the new mapping one cycle early. A write to the spare selector is then checked against every register and against the translation, which exposes a decoder that aliases it onto a real register.

// File: rtl/bank_xlate_pkg.sv
package bank_xlate_pkg;

  typedef enum logic [1:0] {
    RGN_LOW  = 2'd0,
    RGN_WIN  = 2'd1,
    RGN_HIGH = 2'd2
  } region_e;

  typedef enum logic [1:0] {
    SEL_SPLIT     = 2'd0,
    SEL_WIN_BASE  = 2'd1,
    SEL_HIGH_BASE = 2'd2,
    SEL_NONE      = 2'd3
  } cfg_sel_e;

endpackage

// File: rtl/bank_cfg_regs.sv
module bank_cfg_regs
  import bank_xlate_pkg::*;
#(
  parameter int PG_W      = 4,
  parameter int BASE_W    = 8,
  parameter int CFG_W     = 8,
  parameter int SPLIT_RST = 8'hF0,
  parameter int WIN_RST   = 0,
  parameter int HIGH_RST  = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          cfg_sel,
  input  logic                cfg_wr,
  input  logic [CFG_W-1:0]    cfg_wdata,
  output logic [CFG_W-1:0]    cfg_rdata,
  output logic [2*PG_W-1:0]   split,
  output logic [BASE_W-1:0]   win_base,
  output logic [BASE_W-1:0]   high_base
);
  localparam int SPLIT_W = 2 * PG_W;

  cfg_sel_e sel;
  assign sel = cfg_sel_e'(cfg_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      split     <= SPLIT_W'(SPLIT_RST);
      win_base  <= BASE_W'(WIN_RST);
      high_base <= BASE_W'(HIGH_RST);
    end else if (cfg_wr) begin
      case (sel)
        SEL_SPLIT:     split     <= cfg_wdata[SPLIT_W-1:0];
        SEL_WIN_BASE:  win_base  <= cfg_wdata[BASE_W-1:0];
        SEL_HIGH_BASE: high_base <= cfg_wdata[BASE_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else begin
      case (sel)
        SEL_SPLIT:     cfg_rdata <= CFG_W'(split);
        SEL_WIN_BASE:  cfg_rdata <= CFG_W'(win_base);
        SEL_HIGH_BASE: cfg_rdata <= CFG_W'(high_base);
        default:       cfg_rdata <= '0;
      endcase
    end
  end

  AST_SPARE_NOWRITE: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && sel == SEL_NONE) |=> ($stable(split) && $stable(win_base) && $stable(high_base))); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> ($stable(split) && $stable(win_base) && $stable(high_base))); // R8

endmodule

// File: rtl/bank_region_dec.sv
module bank_region_dec
  import bank_xlate_pkg::*;
#(
  parameter int PG_W = 4
) (
  input  logic [PG_W-1:0] page,
  input  logic [PG_W-1:0] win_start,
  input  logic [PG_W-1:0] high_start,
  output region_e         region
);
  // The high region is tested first, so an empty window falls through to it.
  always_comb begin
    if (page >= high_start)     region = RGN_HIGH;
    else if (page >= win_start) region = RGN_WIN;
    else                        region = RGN_LOW;
  end

endmodule

// File: rtl/bank_phys_add.sv
module bank_phys_add
  import bank_xlate_pkg::*;
#(
  parameter int LOG_AW    = 16,
  parameter int PHY_AW    = 20,
  parameter int PAGE_BITS = 12
) (
  input  logic [LOG_AW-1:0]           log_addr,
  input  region_e                     region,
  input  logic [PHY_AW-PAGE_BITS-1:0] win_base,
  input  logic [PHY_AW-PAGE_BITS-1:0] high_base,
  output logic [PHY_AW-1:0]           phys
);
  localparam int BASE_W = PHY_AW - PAGE_BITS;

  logic [BASE_W-1:0] base;

  always_comb begin
    case (region)
      RGN_WIN:  base = win_base;
      RGN_HIGH: base = high_base;
      default:  base = '0;
    endcase
    phys = {base, {PAGE_BITS{1'b0}}} + PHY_AW'(log_addr);
  end

endmodule

// File: rtl/bank_xlate.sv
module bank_xlate
  import bank_xlate_pkg::*;
#(
  parameter int LOG_AW    = 16,
  parameter int PHY_AW    = 20,
  parameter int PAGE_BITS = 12,
  parameter int CFG_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_sel,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              log_valid,
  input  logic [LOG_AW-1:0] log_addr,
  output logic              phys_valid,
  output logic [PHY_AW-1:0] phys_addr,
  output logic [1:0]        phys_region
);
  localparam int PG_W   = LOG_AW - PAGE_BITS;
  localparam int BASE_W = PHY_AW - PAGE_BITS;

  logic [2*PG_W-1:0] split;
  logic [BASE_W-1:0] win_base, high_base;
  logic [PG_W-1:0]   page, win_start, high_start;
  region_e           region;
  logic [PHY_AW-1:0] phys_next;

  bank_cfg_regs #(
    .PG_W(PG_W), .BASE_W(BASE_W), .CFG_W(CFG_W),
    .SPLIT_RST(8'hF0), .WIN_RST(0), .HIGH_RST(0)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .split(split), .win_base(win_base), .high_base(high_base)
  );

  assign page       = log_addr[LOG_AW-1:PAGE_BITS];
  assign win_start  = split[PG_W-1:0];
  assign high_start = split[2*PG_W-1:PG_W];

  bank_region_dec #(.PG_W(PG_W)) u_dec (
    .page(page), .win_start(win_start), .high_start(high_start), .region(region)
  );

  bank_phys_add #(.LOG_AW(LOG_AW), .PHY_AW(PHY_AW), .PAGE_BITS(PAGE_BITS)) u_add (
    .log_addr(log_addr), .region(region), .win_base(win_base),
    .high_base(high_base), .phys(phys_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_valid  <= 1'b0;
      phys_addr   <= '0;
      phys_region <= RGN_LOW;
    end else begin
      phys_valid  <= log_valid;
      phys_addr   <= phys_next;
      phys_region <= region;
    end
  end

  AST_LOW_IDENTITY: assert property (@(posedge clk) disable iff (rst)
    (phys_valid && phys_region == RGN_LOW) |-> phys_addr == PHY_AW'($past(log_addr))); // R2

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> phys_valid == $past(log_valid)); // R7

  AST_WIN_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    (phys_valid && phys_region == RGN_WIN) |-> ($past(win_start) <= $past(high_start))); // R5

endmodule

// File: tb/tb_bank_xlate.sv
module tb_bank_xlate;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  cfg_sel;
  logic        cfg_wr;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic        log_valid;
  logic [15:0] log_addr;
  logic        phys_valid;
  logic [19:0] phys_addr;
  logic [1:0]  phys_region;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] m_split = 8'hF0, m_win = 8'h00, m_high = 8'h00;

  always #4 clk = ~clk;

  bank_xlate dut (
    .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .log_valid(log_valid), .log_addr(log_addr),
    .phys_valid(phys_valid), .phys_addr(phys_addr), .phys_region(phys_region)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic void model(input logic [15:0] a, output logic [19:0] p,
                                output logic [1:0] r, output string tag);
    logic [3:0]  pg;
    logic [7:0]  b;
    logic [20:0] sum;
    pg = a[15:12];
    if (pg >= m_split[7:4])      r = 2'd2;
    else if (pg >= m_split[3:0]) r = 2'd1;
    else                         r = 2'd0;
    b   = (r == 2'd2) ? m_high : (r == 2'd1) ? m_win : 8'h00;
    sum = {1'b0, b, 12'h000} + {5'h00, a};
    p   = sum[19:0];
    if (sum[20])                                     tag = "R6";
    else if (r == 2'd2 && m_split[3:0] > m_split[7:4] && pg >= m_split[3:0]) tag = "R5";
    else if (r == 2'd2)                              tag = "R4";
    else if (r == 2'd1)                              tag = "R3";
    else                                             tag = "R2";
  endfunction

  // Entered at a falling edge; returns at the next falling edge.
  task automatic xlate(input logic [15:0] a);
    logic [19:0] p; logic [1:0] r; string tag;
    model(a, p, r, tag);
    log_valid = 1'b1; log_addr = a;
    @(negedge clk);
    check(tag, "phys_addr", 32'(phys_addr), 32'(p));
    check(tag, "phys_region", 32'(phys_region), 32'(r));
    check("R7", "phys_valid", 32'(phys_valid), 32'd1);
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [7:0] d);
    log_valid = 1'b0; cfg_sel = sel; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    case (sel)
      2'd0: m_split = d;
      2'd1: m_win = d;
      2'd2: m_high = d;
      default: ;
    endcase
  endtask

  task automatic cfg_read(input logic [1:0] sel, input logic [7:0] exp, input string tag);
    cfg_sel = sel;
    @(negedge clk);
    check(tag, "cfg_rdata", 32'(cfg_rdata), 32'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_sel = 2'd0; cfg_wr = 1'b0; cfg_wdata = 8'h00;
    log_valid = 1'b0; log_addr = 16'h0000;
    repeat (3) @(negedge clk);
    check("R1", "phys_valid in reset", 32'(phys_valid), 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset register values and identity map
    cfg_read(2'd0, 8'hF0, "R1");
    cfg_read(2'd1, 8'h00, "R1");
    cfg_read(2'd2, 8'h00, "R1");
    cfg_read(2'd3, 8'h00, "R9");
    for (int pg = 0; pg < 16; pg++) begin
      log_valid = 1'b1; log_addr = 16'(pg * 4096 + 16'h0ABC);
      @(negedge clk);
      check("R1", "identity", 32'(phys_addr), 32'(pg * 4096 + 16'h0ABC));
    end

    // R10: worked example
    cfg_write(2'd0, 8'h84);
    cfg_write(2'd1, 8'h08);
    log_valid = 1'b1; log_addr = 16'h4000;
    @(negedge clk);
    check("R10", "phys_addr", 32'(phys_addr), 32'h0C000);
    check("R10", "phys_region", 32'(phys_region), 32'd1);

    // R7: valid low propagates
    log_valid = 1'b0;
    @(negedge clk);
    check("R7", "phys_valid low", 32'(phys_valid), 32'd0);

    // Every split value, every page, fixed bases
    cfg_write(2'd1, 8'h3C);
    cfg_write(2'd2, 8'hF4);
    for (int s = 0; s < 256; s++) begin
      cfg_write(2'd0, 8'(s));
      for (int pg = 0; pg < 16; pg++) xlate(16'(pg * 4096 + 16'h07A5));
    end

    // Several base pairs, page edges
    for (int k = 0; k < 4; k++) begin
      cfg_write(2'd0, (k == 0) ? 8'h84 : (k == 1) ? 8'h48 : (k == 2) ? 8'hA3 : 8'h5C);
      cfg_write(2'd1, (k == 0) ? 8'hFF : (k == 1) ? 8'h10 : (k == 2) ? 8'hF8 : 8'h01);
      cfg_write(2'd2, (k == 0) ? 8'hFB : (k == 1) ? 8'hF9 : (k == 2) ? 8'h20 : 8'hFE);
      for (int pg = 0; pg < 16; pg++) begin
        xlate(16'(pg * 4096));
        xlate(16'(pg * 4096 + 4095));
      end
    end

    // R6: explicit wrap
    cfg_write(2'd0, 8'h84);
    cfg_write(2'd1, 8'hFF);
    log_valid = 1'b1; log_addr = 16'h4123;
    @(negedge clk);
    check("R6", "wrap", 32'(phys_addr), 32'h03123);

    // R8: write in the same cycle as a translation uses old base
    cfg_sel = 2'd1; cfg_wdata = 8'h20; cfg_wr = 1'b1;
    log_valid = 1'b1; log_addr = 16'h5000;
    @(negedge clk);
    cfg_wr = 1'b0;
    check("R8", "same-cycle old base", 32'(phys_addr), 32'h04000);
    m_win = 8'h20;
    log_addr = 16'h5000;
    @(negedge clk);
    check("R8", "next-cycle new base", 32'(phys_addr), 32'h25000);

    // R9: spare selector write ignored
    cfg_write(2'd3, 8'hAA);
    cfg_read(2'd0, 8'h84, "R9");
    cfg_read(2'd1, 8'h20, "R9");
    cfg_read(2'd2, 8'hFE, "R9");
    cfg_read(2'd3, 8'h00, "R9");
    xlate(16'h5000);
    xlate(16'hC001);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule